// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI and LO Result Registers

This unit performs 32-bit multiplication and division for a RISC core, one bit per clock, and holds its results in two dedicated 32-bit registers, HI and LO. A start strobe launches an operation. The operation code selects signed or unsigned multiplication or division. Two 32-bit operands come with the strobe.

A multiplication leaves the 64-bit product with its upper half in HI and its lower half in LO. A division leaves the remainder in HI and the quotient in LO. Both registers are always visible on read ports, so the core's move-from-HI and move-from-LO instructions can be served directly. The core stalls on `busy_o` and may read once `done_o` has pulsed.

Operands are first converted to magnitudes. Thirty-two iterations of shift-and-add or restoring subtraction follow, and one last cycle applies the signs and writes HI and LO. Division by zero completes normally and produces fixed values instead of a trap.

Top module: `mdu_hilo`

## Requirements
- R1: During and after reset, `busy_o`, `done_o`, `hi_o` and `lo_o` are all zero.
- R2: The operation code on `op_i` uses bit 1 to select divide (1) or multiply (0), and bit 0 to select unsigned (1) or two's-complement (0). When `start_i` is high at a clock edge while `busy_o` is low, the request is accepted and `busy_o` is high in the next cycle.
- R3: `busy_o` stays high for 33 cycles after the accepting edge. `done_o` is then high for exactly one cycle, in which `busy_o` is low. `busy_o` and `done_o` are never high together.
- R4: For multiply, HI receives bits 63:32 and LO receives bits 31:0 of the full product. Code 00 treats the operands as signed and code 01 treats them as unsigned.
- R5: Unsigned divide (code 11) leaves the quotient in LO and the remainder in HI.
- R6: Signed divide (code 10) truncates the quotient toward zero, and the remainder takes the sign of the dividend. Dividing the most negative value by minus one gives LO = 0x80000000 and HI = 0.
- R7: Dividing by zero, signed or unsigned, gives LO = 0xFFFFFFFF and HI equal to the dividend operand as given.
- R8: A start request made while `busy_o` is high is ignored. Its operands and code do not affect the result of the operation in progress.
- R9: HI and LO keep their previous values throughout an operation and change only in the cycle in which `done_o` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe |
| op_i | input | 2 | Operation code (bit 1 divide, bit 0 unsigned) |
| opa_i | input | 32 | First operand / dividend |
| opb_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |

## Verification
The assertions assume reset is applied before the first request. They also assume that `start_i`, `op_i` and the operands are stable around the clock edge, so that one sampled value decides each request.

The stimulus drives every input on the falling edge and holds reset for several cycles at the start. It launches requests only while the unit is idle or in its completion cycle. The single exception is the deliberate strobes issued during an operation, which exercise the rule that such requests are ignored.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  // bit 1: divide, bit 0: unsigned
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;
endpackage

// File: rtl/mdu_prep.sv
module mdu_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_main,
  output logic         neg_rem,
  output logic         b_zero
);
  logic is_signed, a_neg, b_neg;

  always_comb begin
    is_signed = ~op[0];
    a_neg     = is_signed & a[W-1];
    b_neg     = is_signed & b[W-1];
    mag_a     = a_neg ? (~a + 1'b1) : a;
    mag_b     = b_neg ? (~b + 1'b1) : b;
    neg_main  = a_neg ^ b_neg;
    neg_rem   = a_neg;
    b_zero    = (b == '0);
  end
endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic [W:0]   upr,
  input  logic [W-1:0] lwr,
  input  logic [W-1:0] mag_b,
  output logic [W:0]   upr_n,
  output logic [W-1:0] lwr_n
);
  logic [W:0]     sum;
  logic [2*W:0]   shifted;
  logic [W:0]     shl;
  logic [W+1:0]   trial;

  always_comb begin
    // shift-and-add step
    sum     = lwr[0] ? ({1'b0, upr[W-1:0]} + {1'b0, mag_b}) : {1'b0, upr[W-1:0]};
    shifted = {sum, lwr} >> 1;
    // restoring division step
    shl     = {upr[W-1:0], lwr[W-1]};
    trial   = {1'b0, shl} - {2'b00, mag_b};
    if (is_div) begin
      if (!trial[W+1]) begin
        upr_n = trial[W:0];
        lwr_n = {lwr[W-2:0], 1'b1};
      end else begin
        upr_n = shl;
        lwr_n = {lwr[W-2:0], 1'b0};
      end
    end else begin
      upr_n = shifted[2*W:W];
      lwr_n = shifted[W-1:0];
    end
  end
endmodule

// File: rtl/mdu_fixup.sv
module mdu_fixup #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         b_zero,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic [W-1:0] raw_a,
  input  logic [W:0]   upr,
  input  logic [W-1:0] lwr,
  output logic [W-1:0] hi_n,
  output logic [W-1:0] lo_n
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = {upr[W-1:0], lwr};
    if (neg_main) prod = ~prod + 1'b1;
    if (!is_div) begin
      hi_n = prod[2*W-1:W];
      lo_n = prod[W-1:0];
    end else if (b_zero) begin
      hi_n = raw_a;
      lo_n = '1;
    end else begin
      lo_n = neg_main ? (~lwr + 1'b1) : lwr;
      hi_n = neg_rem ? (~upr[W-1:0] + 1'b1) : upr[W-1:0];
    end
  end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  import mdu_pkg::*;

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  mdu_op_e          op_q;
  logic [W:0]       upr_q;
  logic [W-1:0]     lwr_q, magb_q, rawa_q, hi_q, lo_q;
  logic             negm_q, negr_q, bz_q;

  logic [W-1:0] p_maga, p_magb;
  logic         p_negm, p_negr, p_bz;
  logic [W:0]   s_upr;
  logic [W-1:0] s_lwr, f_hi, f_lo;
  logic         accept;

  assign accept = start_i & ~busy_q;

  mdu_prep #(.W(W)) u_prep (
    .op(op_i), .a(opa_i), .b(opb_i),
    .mag_a(p_maga), .mag_b(p_magb),
    .neg_main(p_negm), .neg_rem(p_negr), .b_zero(p_bz)
  );

  mdu_step #(.W(W)) u_step (
    .is_div(op_q[1]), .upr(upr_q), .lwr(lwr_q), .mag_b(magb_q),
    .upr_n(s_upr), .lwr_n(s_lwr)
  );

  mdu_fixup #(.W(W)) u_fix (
    .is_div(op_q[1]), .b_zero(bz_q), .neg_main(negm_q), .neg_rem(negr_q),
    .raw_a(rawa_q), .upr(upr_q), .lwr(lwr_q),
    .hi_n(f_hi), .lo_n(f_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MULS;
      upr_q  <= '0;
      lwr_q  <= '0;
      magb_q <= '0;
      rawa_q <= '0;
      negm_q <= 1'b0;
      negr_q <= 1'b0;
      bz_q   <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        op_q   <= mdu_op_e'(op_i);
        upr_q  <= '0;
        lwr_q  <= p_maga;
        magb_q <= p_magb;
        rawa_q <= opa_i;
        negm_q <= p_negm;
        negr_q <= p_negr;
        bz_q   <= p_bz;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= f_hi;
          lo_q   <= f_lo;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          upr_q <= s_upr;
          lwr_q <= s_lwr;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy_q)); // R3
  AST_IDLE_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> busy_q); // R2
  AST_HILO_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (done_q || ($stable(hi_q) && $stable(lo_q)))); // R9
  AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q != '0)); // R8
endmodule

// File: tb/mdu_hilo_tb.sv
module mdu_hilo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R4";

  // reference model state
  bit          m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [31:0] m_hi = '0, m_lo = '0, m_nhi = '0, m_nlo = '0;

  always #2 clk = ~clk; // 250 MHz

  mdu_hilo u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  function automatic logic [63:0] ref_result(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub, p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (op)
      2'b00: p = 64'(sa * sb);
      2'b01: p = ua * ub;
      default: begin
        if (b == 0) p = {a, 32'hFFFF_FFFF};
        else if (op == 2'b11) p = {32'(ua % ub), 32'(ua / ub)};
        else begin
          q = sa / sb;
          r = sa % sb;
          p = {32'(r), 32'(q)};
        end
      end
    endcase
    return p;
  endfunction

  always @(posedge clk) begin
    logic [63:0] res;
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_hi = '0; m_lo = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 33) begin
          m_busy = 0; m_done = 1; m_hi = m_nhi; m_lo = m_nlo;
        end
      end else if (start_i) begin
        res = ref_result(op_i, opa_i, opb_i);
        m_nhi = res[63:32]; m_nlo = res[31:0];
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R3", "busy_o", 32'(busy_o), 32'(m_busy));
      check("R3", "done_o", 32'(done_o), 32'(m_done));
      check(m_busy ? "R9" : cur_req, "hi_o", hi_o, m_hi);
      check(m_busy ? "R9" : cur_req, "lo_o", lo_o, m_lo);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    if (cycles > 150000) begin end
    wait (cycles >= 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    summary();
  end

  task automatic wait_done();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  task automatic run_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    if (op[1] && b == 0) cur_req = "R7";
    else if (op == 2'b10) cur_req = "R6";
    else if (op == 2'b11) cur_req = "R5";
    else cur_req = "R4";
    start_i = 1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 0;
    check("R2", "busy after start", 32'(busy_o), 32'd1);
    wait_done();
  endtask

  initial begin
    logic [63:0] exp;
    repeat (4) @(negedge clk);
    check("R1", "busy in reset", 32'(busy_o), 0);
    check("R1", "done in reset", 32'(done_o), 0);
    check("R1", "hi in reset", hi_o, 0);
    check("R1", "lo in reset", lo_o, 0);
    rst = 0;
    @(negedge clk);
    check("R1", "hi after reset", hi_o, 0);

    // multiply, R4
    run_op(2'b00, 32'd7, 32'd6);
    run_op(2'b00, -32'sd5, 32'd3);
    run_op(2'b00, -32'sd123456, -32'sd654321);
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000);
    exp = ref_result(2'b00, 32'hFFFF_FFFF, 32'd2);
    run_op(2'b00, 32'hFFFF_FFFF, 32'd2);
    check("R4", "signed -1*2 hi", hi_o, exp[63:32]);
    // divide R5/R6
    run_op(2'b11, 32'd100, 32'd7);
    run_op(2'b11, 32'hFFFF_FFFF, 32'd16);
    run_op(2'b10, -32'sd7, 32'd2);
    check("R6", "-7/2 quotient", lo_o, 32'hFFFF_FFFD);
    check("R6", "-7/2 remainder", hi_o, 32'hFFFF_FFFF);
    run_op(2'b10, 32'd7, -32'sd2);
    run_op(2'b10, -32'sd7, -32'sd2);
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R6", "min/-1 lo", lo_o, 32'h8000_0000);
    check("R6", "min/-1 hi", hi_o, 32'h0);
    // divide by zero R7
    run_op(2'b10, -32'sd9, 32'd0);
    check("R7", "signed div0 hi", hi_o, 32'hFFFF_FFF7);
    check("R7", "signed div0 lo", lo_o, 32'hFFFF_FFFF);
    run_op(2'b11, 32'h1234_5678, 32'd0);
    check("R7", "unsigned div0 hi", hi_o, 32'h1234_5678);

    // start while busy ignored, R8
    exp = ref_result(2'b01, 32'd1000, 32'd1000);
    cur_req = "R8";
    start_i = 1; op_i = 2'b01; opa_i = 32'd1000; opb_i = 32'd1000;
    @(negedge clk);
    op_i = 2'b11; opa_i = 32'd5; opb_i = 32'd0; // still strobing while busy
    repeat (10) @(negedge clk);
    start_i = 0;
    wait_done();
    check("R8", "hi after ignored start", hi_o, exp[63:32]);
    check("R8", "lo after ignored start", lo_o, exp[31:0]);
    @(negedge clk);
    check("R8", "idle after ignored start", 32'(busy_o), 0);

    // back-to-back start in done cycle
    run_op(2'b11, 32'd50, 32'd5);
    run_op(2'b00, 32'd3, 32'd3);

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (i % 9 == 0) ? 32'd0 : ((i % 3 == 0) ? ($urandom & 32'hFF) : $urandom);
      run_op(2'(i % 4), ra, rb);
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule